// File: doc/BRIEF.md
# Dithered PWM DAC

This block turns an 8-bit level into a single-bit pulse train. An RC filter outside the chip smooths that pulse train into a voltage. Each PWM period is 256 clocks long. In each period the pin is high for a number of clocks set by the level.

A 16-bit dither word raises the resolution. Sixteen periods in a row form one sequence. Each bit of the dither word belongs to one period of the sequence, and a set bit adds one clock of high time to its own period. The average over a sequence therefore moves in steps of 1/16 of one count.

The level and the dither word are sampled together, and only on the last clock of a sequence. New values then take effect on a sequence boundary and never partway through one. A chip that needs several such outputs places one copy of this block for each of them.

Top module: `pwm_dither_dac`

## Requirements
- R1: While `rst_n` is low and for the first full sequence after it rises, `pwm_o` is 0, because the applied level and dither word reset to zero.
- R2: A period is 256 clocks. With the period's dither bit clear, `pwm_o` is high for the first `duty_i` clocks of the period and low for the rest. The output is registered, so the whole pattern is one clock late relative to the internal position counter.
- R3: When the dither bit of a period is set, that period is high for `duty_i`+1 clocks.
- R4: The period index starts at 0 and steps by one per period, wrapping from 15 back to 0. Period k of a sequence uses bit k of `mask_i`, and bit 0 belongs to the first period.
- R5: A level of 255 with the period's dither bit set keeps the pin high for all 256 clocks of that period. A level of 0 with the bit clear keeps it low for the whole period.
- R6: `duty_i` and `mask_i` are captured only at the clock edge that ends a sequence. Changes at any other time have no effect until the next sequence, and a change presented just before that edge is taken.
- R7: Over one sequence, the total number of high clocks equals 16·duty + the number of ones in the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| duty_i | input | 8 | Level: high clocks per period |
| mask_i | input | 16 | Dither word, one bit per period of a sequence |
| pwm_o | output | 1 | Registered pulse output |

## Verification
The capture of a new setting and the last period of the old setting's sequence fall on the same clock edge. The period wrap from 15 to 0 also lands on that edge. The bench changes the inputs on the very clock before that edge and in the middle of a sequence. A behavioural model, which counts clocks since reset, decides which setting owns every output cycle, and the output is compared on every clock. A per-sequence high-time total confirms that neither setting leaked into the other sequence.

// File: rtl/pdac_pkg.sv
// Package: default sizes shared by the dithered PWM DAC modules.
// Assumes: the dither word has one bit per period of a sequence.
package pdac_pkg;
    localparam int unsigned POS_W_DEF = 8;   // bits of the in-period position
    localparam int unsigned IDX_W_DEF = 4;   // bits of the period index
endpackage

// File: rtl/pdac_timebase.sv
// Module: pdac_timebase
// Runs the in-period position counter and the period index.
// Flags the final clock of a sequence, which is the last position of the
// last period.
// Assumes: free-running after reset; the widths give power-of-two lengths.
module pdac_timebase #(
    parameter int unsigned POS_W = 8,
    parameter int unsigned IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [POS_W-1:0] pos,
    output logic [IDX_W-1:0] idx,
    output logic             seq_last
);
    logic period_last;

    assign period_last = &pos;
    assign seq_last    = period_last & (&idx);

    // Advance the position every clock, and the index at each period end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos <= '0;
            idx <= '0;
        end else begin
            pos <= pos + 1'b1;
            if (period_last) begin
                idx <= idx + 1'b1;
            end
        end
    end

    // R4: the index advances by exactly one when a period ends mid-sequence
    p_idx_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (period_last && !(&idx)) |=> (idx == $past(idx) + 1'b1));
    // R4: the index wraps to zero when a sequence ends
    p_idx_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        seq_last |=> (idx == '0 && pos == '0));
    // R4: the index stays put inside a period
    p_idx_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !period_last |=> $stable(idx));
endmodule

// File: rtl/pdac_shadow.sv
// Module: pdac_shadow
// Holds the level and dither word that are in force. It reloads them from
// the inputs only on the load strobe, which marks the end of a sequence.
// Assumes: the inputs are synchronous to clk.
module pdac_shadow #(
    parameter int unsigned DUTY_W = 8,
    parameter int unsigned MASK_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DUTY_W-1:0] duty_in,
    input  logic [MASK_W-1:0] mask_in,
    output logic [DUTY_W-1:0] act_duty,
    output logic [MASK_W-1:0] act_mask
);
    // Capture a new setting at the sequence boundary only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_duty <= '0;
            act_mask <= '0;
        end else if (load) begin
            act_duty <= duty_in;
            act_mask <= mask_in;
        end
    end

    // R6: no change of the applied setting away from the boundary
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(act_duty) && $stable(act_mask)));
    // R6: the boundary takes the values that were present on the inputs
    p_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (act_duty == $past(duty_in) && act_mask == $past(mask_in)));
endmodule

// File: rtl/pdac_compare.sv
// Module: pdac_compare
// Forms the period's effective level, which is the level plus its dither
// bit, one bit wider so that 255+1 reaches a full period. It then registers
// the position-below-level comparison onto the output pin.
// Assumes: pos and idx come from pdac_timebase.
module pdac_compare #(
    parameter int unsigned POS_W = 8,
    parameter int unsigned IDX_W = 4,
    localparam int unsigned MASK_W = 1 << IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [POS_W-1:0]  pos,
    input  logic [IDX_W-1:0]  idx,
    input  logic [POS_W-1:0]  act_duty,
    input  logic [MASK_W-1:0] act_mask,
    output logic              pwm
);
    logic [POS_W:0] eff;

    // Effective level of the current period.
    always_comb begin
        eff = {1'b0, act_duty} + {{POS_W{1'b0}}, act_mask[idx]};
    end

    // Register the comparison so that the pin is free of glitches.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwm <= 1'b0;
        end else begin
            pwm <= ({1'b0, pos} < eff);
        end
    end

    // R5: a full-scale effective level drives the pin high
    p_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
        eff[POS_W] |=> pwm);
    // R5: a zero effective level keeps the pin low
    p_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (eff == '0) |=> !pwm);
    // R2: every nonzero period starts high
    p_start_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pos == '0 && eff != '0) |=> pwm);
endmodule

// File: rtl/pwm_dither_dac.sv
// Module: pwm_dither_dac
// Single-bit PWM DAC with a 16-period dither sequence. It ties together the
// timebase, the setting shadow and the comparator.
// Assumes: synchronous active-low reset; inputs synchronous to clk.
module pwm_dither_dac
    import pdac_pkg::*;
#(
    parameter int unsigned POS_W = POS_W_DEF,
    parameter int unsigned IDX_W = IDX_W_DEF,
    localparam int unsigned MASK_W = 1 << IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [POS_W-1:0]  duty_i,
    input  logic [MASK_W-1:0] mask_i,
    output logic              pwm_o
);
    logic [POS_W-1:0]  pos;
    logic [IDX_W-1:0]  idx;
    logic              seq_last;
    logic [POS_W-1:0]  act_duty;
    logic [MASK_W-1:0] act_mask;

    pdac_timebase #(.POS_W(POS_W), .IDX_W(IDX_W)) u_timebase (
        .clk      (clk),
        .rst_n    (rst_n),
        .pos      (pos),
        .idx      (idx),
        .seq_last (seq_last)
    );

    pdac_shadow #(.DUTY_W(POS_W), .MASK_W(MASK_W)) u_shadow (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (seq_last),
        .duty_in  (duty_i),
        .mask_in  (mask_i),
        .act_duty (act_duty),
        .act_mask (act_mask)
    );

    pdac_compare #(.POS_W(POS_W), .IDX_W(IDX_W)) u_compare (
        .clk      (clk),
        .rst_n    (rst_n),
        .pos      (pos),
        .idx      (idx),
        .act_duty (act_duty),
        .act_mask (act_mask),
        .pwm      (pwm_o)
    );
endmodule

// File: tb/pwm_dither_dac_tb.sv
// Bench: a behavioural model counts clocks since reset, derives position,
// period and applied setting from that count, and is compared on every clock.
module pwm_dither_dac_tb;
    localparam time CLK_PERIOD = 10ns;
    localparam int  PER = 256;
    localparam int  SEQ = 4096;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  duty_i = 8'd100;
    logic [15:0] mask_i = 16'hA5A5;
    logic        pwm_o;

    int checks = 0;
    int errors = 0;
    bit chk_on = 0;

    // model state
    int          mt = 0;
    logic [7:0]  ad = '0;
    logic [15:0] am = '0;
    bit          exp_pwm = 0;
    string       tag = "R1";

    // per-sequence high-time tally
    int          hc = 0;
    int          wd = 0;
    logic [15:0] wm = '0;

    pwm_dither_dac u_dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .duty_i (duty_i),
        .mask_i (mask_i),
        .pwm_o  (pwm_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural reference: the value the pin takes after this edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            mt = 0; ad = '0; am = '0; exp_pwm = 0; tag = "R1";
        end else begin
            int p, k, e;
            p = mt % PER;
            k = (mt / PER) % 16;
            e = int'(ad) + (am[k] ? 1 : 0);
            exp_pwm = (p < e);
            if (mt < SEQ)               tag = "R1";
            else if (e == 256 || e == 0) tag = "R5";
            else if (am[k])             tag = "R3 R4";
            else                        tag = "R2 R4";
            if (mt % SEQ == SEQ - 1) begin
                ad = duty_i; am = mask_i;
            end
            mt++;
        end
    end

    // Per-clock comparison and per-sequence total.
    always @(negedge clk) begin
        if (chk_on && mt >= 1) begin
            int off;
            checks++;
            if (pwm_o !== exp_pwm) begin
                errors++;
                $display("FAIL %s cycle %0d pwm_o actual %b expected %b", tag, mt, pwm_o, exp_pwm);
            end
            off = (mt - 1) % SEQ;
            if (off == 0) begin
                hc = 0; wd = int'(ad); wm = am;
            end
            if (pwm_o === 1'b1) hc++;
            if (off == SEQ - 1) begin
                int want;
                want = 16 * wd + $countones(wm);
                checks++;
                if (hc != want) begin
                    errors++;
                    $display("FAIL R7 R6 sequence %0d high clocks actual %0d expected %0d",
                             (mt - 1) / SEQ, hc, want);
                end
            end
        end
    end

    task automatic wait_to(input int t);
        while (mt < t) @(negedge clk);
    endtask

    // Stimulus.
    initial begin
        repeat (4) @(negedge clk);
        for (int i = 0; i < 2; i++) begin
            checks++;
            if (pwm_o !== 1'b0) begin
                errors++;
                $display("FAIL R1 pwm_o in reset actual %b expected 0", pwm_o);
            end
            @(negedge clk);
        end
        rst_n = 1'b1;
        chk_on = 1;
        // sequence 1 takes 100/A5A5; change mid-sequence 1, applies in 2
        wait_to(SEQ + 1000);
        duty_i = 8'd255; mask_i = 16'h0001;
        wait_to(2 * SEQ + 2000);
        duty_i = 8'd0;   mask_i = 16'h0000;
        wait_to(3 * SEQ + 10);
        duty_i = 8'd0;   mask_i = 16'hFFFF;
        wait_to(4 * SEQ + 5);
        duty_i = 8'd255; mask_i = 16'hFFFF;
        // R6 boundary: new value on the very clock before capture
        wait_to(6 * SEQ - 1);
        duty_i = 8'd37;  mask_i = 16'h8001;
        @(negedge clk);
        duty_i = 8'd200; mask_i = 16'h7777;
        wait_to(7 * SEQ + 4);
        @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule